// File: doc/BRIEF.md
# Clock Time-Setting and Test Controller

This block is the timekeeping core of a four-digit clock. It divides a 262144 Hz base clock down to one-second ticks and keeps seconds, minutes and hours, with 12-hour counting (plus an AM/PM flag) or 24-hour counting. Calibration works by holding back a programmable number of base-clock cycles in every second. This stretches each second to make up for a crystal that is trimmed to run fast.

Two active-low push buttons set the time. One steps the hours and the other steps the minutes. Each press gives one step at once. If the button is still held after a second, it repeats once a second. A minute step also zeroes the seconds. Holding both buttons lights every display segment, and letting go restarts the clock from its power-up time. A test input freezes timekeeping and makes button timing 64 times faster, so the display can be checked quickly. A colon output either blinks once per second or stays lit.

Top module: `clock_set_ctrl`

## Requirements
- R1: After reset the time is 0 seconds, 0 minutes and AM (`pm`=0). Hours are 1 when `mode12`=1 and 0 when `mode12`=0.
- R2: A button level is accepted only after 4 equal consecutive samples. Samples are taken every CLK_HZ/64 base cycles. A shorter press has no effect.
- R3: While `set_en` is low, both buttons are ignored. The time does not change and `seg_all_on` stays low.
- R4: An accepted hour press adds one hour at once. While the button stays held, one more hour is added every 64 sample periods (1 s).
- R5: A minute press steps the minutes in the same way as R4 and clears the seconds to 0. A manual step from 59 to 0 leaves the hours unchanged.
- R6: In 12-hour mode, hours go 11 to 12, which toggles `pm`, and 12 to 1. In 24-hour mode, hours go 23 to 0.
- R7: Outside test mode the seconds advance once per second. Seconds 59 to 0 carries one minute, and minutes 59 to 0 carries one hour.
- R8: While both accepted buttons are pressed, `seg_all_on` is high and no step occurs. When both are released, the time returns to its R1 values.
- R9: In test mode the seconds, minutes and hours never advance on their own. The sample period and the repeat interval are both 64 times shorter.
- R10: With `flash_sel`=1, `colon` is high in the first half of each second and low in the second half. With `flash_sel`=0, it is always high.
- R11: Each second lasts CLK_HZ + `trim` base-clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock, CLK_HZ (262144 Hz by default) |
| rst_n | input | 1 | Asynchronous active-low power-up reset |
| s_hr_n | input | 1 | Hour button, low when pressed |
| s_min_n | input | 1 | Minute button, low when pressed |
| set_en | input | 1 | High lets the buttons act |
| mode12 | input | 1 | 1 selects 12-hour counting, 0 selects 24-hour |
| flash_sel | input | 1 | 1 makes the colon blink at 1 Hz |
| test_mode | input | 1 | 1 freezes time and speeds button timing up by 64 |
| trim | input | TRIM_W | Base cycles held back per second |
| sec | output | 6 | Seconds, binary 0..59 |
| min | output | 6 | Minutes, binary 0..59 |
| hr | output | 5 | Hours, binary (1..12 or 0..23) |
| pm | output | 1 | 1 means PM in 12-hour mode |
| colon | output | 1 | Colon segment on |
| seg_all_on | output | 1 | Request to light all segments |

## Verification
The hardest case to reach from the ports is a carry that runs through a whole minute into the hours. At full rate this needs 60 real seconds, and setting minutes to 59 normally needs 59 debounced presses. The bench first uses test mode to freeze the clock and step the minutes to 59 in a few cycles per press. It then releases test mode on a second instance built with a 256 Hz base clock, locks onto a seconds edge, and samples just after the 60th tick. The 1 s repeat window is also hard to hit reliably. Hold times are therefore chosen halfway between repeat boundaries, so that debounce latency cannot change the count.

// File: rtl/clock_set_ctrl.sv
module clock_set_ctrl #(
  parameter int CLK_HZ  = 262144,
  parameter int TRIM_W  = 6,
  parameter int DEB_LEN = 4,
  parameter int SPEEDUP = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_hr_n,
  input  logic              s_min_n,
  input  logic              set_en,
  input  logic              mode12,
  input  logic              flash_sel,
  input  logic              test_mode,
  input  logic [TRIM_W-1:0] trim,
  output logic [5:0]        sec,
  output logic [5:0]        min,
  output logic [4:0]        hr,
  output logic              pm,
  output logic              colon,
  output logic              seg_all_on
);
  localparam int PW    = $clog2(CLK_HZ);
  localparam int SMP_N = CLK_HZ / 64;
  localparam int SMP_T = (SMP_N / SPEEDUP > 0) ? SMP_N / SPEEDUP : 1;
  localparam logic [PW-1:0] MASK_N = PW'(SMP_N - 1);
  localparam logic [PW-1:0] MASK_T = PW'(SMP_T - 1);
  localparam logic [PW-1:0] TOP    = PW'(CLK_HZ - 1);
  localparam logic [PW-1:0] HALF   = PW'(CLK_HZ / 2);

  logic [PW-1:0]      pre;
  logic [TRIM_W-1:0]  skip;
  logic [DEB_LEN-1:0] sh_h, sh_m;
  logic               db_h, db_m, prev_h, prev_m, both_seen;
  logic [5:0]         hold;

  wire run      = (skip == '0);
  wire sec_tick = run && (pre == TOP);
  wire [PW-1:0] mask = test_mode ? MASK_T : MASK_N;
  wire smp_tick = run && ((pre & mask) == mask);

  wire act_h     = set_en & db_h;
  wire act_m     = set_en & db_m;
  wire both      = act_h & act_m;
  wire rel_reset = both_seen & ~act_h & ~act_m;
  wire one       = (act_h ^ act_m) & ~both_seen;
  wire edge_h    = act_h & ~prev_h & ~act_m & ~both_seen;
  wire edge_m    = act_m & ~prev_m & ~act_h & ~both_seen;
  wire rep       = one && smp_tick && (hold == 6'd63);
  wire step_h    = edge_h | (rep & act_h);
  wire step_m    = edge_m | (rep & act_m);
  wire time_tick = sec_tick && !test_mode;
  wire carry_m   = time_tick && (sec == 6'd59);
  wire carry_h   = carry_m && (min == 6'd59) && !step_m;

  wire [DEB_LEN-1:0] nh = {sh_h[DEB_LEN-2:0], ~s_hr_n};
  wire [DEB_LEN-1:0] nm = {sh_m[DEB_LEN-2:0], ~s_min_n};

  function automatic logic [4:0] hr_next(input logic [4:0] h, input logic m12);
    if (m12) return (h >= 5'd12) ? 5'd1 : h + 5'd1;
    return (h >= 5'd23) ? 5'd0 : h + 5'd1;
  endfunction

  assign colon      = flash_sel ? (pre < HALF) : 1'b1;
  assign seg_all_on = both;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_h <= '0; sh_m <= '0; db_h <= 1'b0; db_m <= 1'b0;
    end else if (smp_tick) begin
      sh_h <= nh; sh_m <= nm;
      if (&nh) db_h <= 1'b1; else if (~|nh) db_h <= 1'b0;
      if (&nm) db_m <= 1'b1; else if (~|nm) db_m <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_h <= 1'b0; prev_m <= 1'b0; both_seen <= 1'b0; hold <= '0;
    end else begin
      prev_h <= act_h;
      prev_m <= act_m;
      if (both) both_seen <= 1'b1;
      else if (rel_reset) both_seen <= 1'b0;
      if (!one || edge_h || edge_m) hold <= '0;
      else if (smp_tick) hold <= hold + 6'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre <= '0; skip <= '0;
      sec <= '0; min <= '0; hr <= mode12 ? 5'd1 : 5'd0; pm <= 1'b0;
    end else if (rel_reset) begin
      pre <= '0; skip <= '0;
      sec <= '0; min <= '0; hr <= mode12 ? 5'd1 : 5'd0; pm <= 1'b0;
    end else begin
      if (!run) skip <= skip - 1'b1;
      else if (pre == TOP) begin
        pre  <= '0;
        skip <= trim;
      end else pre <= pre + 1'b1;

      if (step_m) begin
        min <= (min >= 6'd59) ? 6'd0 : min + 6'd1;
        sec <= '0;
      end else if (time_tick) begin
        sec <= carry_m ? 6'd0 : sec + 6'd1;
        if (carry_m) min <= (min == 6'd59) ? 6'd0 : min + 6'd1;
      end

      if (step_h || carry_h) begin
        hr <= hr_next(hr, mode12);
        if (mode12 && hr == 5'd11) pm <= ~pm;
      end
    end
  end
endmodule

module clock_set_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       test_mode,
  input logic       flash_sel,
  input logic       mode12,
  input logic       set_en,
  input logic [5:0] sec,
  input logic [5:0] min,
  input logic [4:0] hr,
  input logic       colon,
  input logic       seg_all_on
);
  assert_time_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sec < 6'd60) && (min < 6'd60) && (hr < 5'd24));
  assert_sec_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sec)) |-> (sec == 6'd0) || (sec == $past(sec) + 6'd1));
  assert_min_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(min)) |-> (min == 6'd0) || (min == $past(min) + 6'd1));
  assert_test_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (test_mode && $past(test_mode) && !$stable(sec)) |-> (sec == 6'd0));
  assert_hr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(hr) && $stable(mode12)) |-> (hr == $past(hr) + 5'd1) || (hr <= 5'd1));
  assert_colon_static_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !flash_sel |-> colon);
  assert_enable_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    seg_all_on |-> set_en);
endmodule

bind clock_set_ctrl clock_set_ctrl_chk chk (
  .clk(clk), .rst_n(rst_n), .test_mode(test_mode), .flash_sel(flash_sel),
  .mode12(mode12), .set_en(set_en), .sec(sec), .min(min), .hr(hr),
  .colon(colon), .seg_all_on(seg_all_on)
);

// File: tb/tb_clock_set_ctrl.sv
module tb_clock_set_ctrl;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, s_hr_n, s_min_n, set_en, mode12, flash_sel, test_mode;
  logic [5:0] trim;
  logic [5:0] sec, min, sec2, min2;
  logic [4:0] hr, hr2;
  logic pm, colon, seg_all_on, pm2, colon2, seg2;

  clock_set_ctrl #(.CLK_HZ(4096)) dut (
    .clk(clk), .rst_n(rst_n), .s_hr_n(s_hr_n), .s_min_n(s_min_n), .set_en(set_en),
    .mode12(mode12), .flash_sel(flash_sel), .test_mode(test_mode), .trim(trim),
    .sec(sec), .min(min), .hr(hr), .pm(pm), .colon(colon), .seg_all_on(seg_all_on));

  clock_set_ctrl #(.CLK_HZ(256)) dut2 (
    .clk(clk), .rst_n(rst_n), .s_hr_n(s_hr_n), .s_min_n(s_min_n), .set_en(set_en),
    .mode12(mode12), .flash_sel(flash_sel), .test_mode(test_mode), .trim(trim),
    .sec(sec2), .min(min2), .hr(hr2), .pm(pm2), .colon(colon2), .seg_all_on(seg2));

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic press(input bit hour, input int hold_c, input int settle);
    if (hour) s_hr_n = 1'b0; else s_min_n = 1'b0;
    tick(hold_c);
    s_hr_n = 1'b1; s_min_n = 1'b1;
    tick(settle);
  endtask

  task automatic press_both(input int hold_c, input int settle);
    s_hr_n = 1'b0; s_min_n = 1'b0;
    tick(hold_c);
    s_hr_n = 1'b1; s_min_n = 1'b1;
    tick(settle);
  endtask

  task automatic wait_sec_change(output int cycles);
    logic [5:0] s0;
    s0 = sec;
    cycles = 0;
    while (sec == s0 && cycles < 20000) begin
      tick(1);
      cycles++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int eh, epm, c, s_before, m_before, h_before;
    rst_n = 0; s_hr_n = 1; s_min_n = 1; set_en = 1; mode12 = 1;
    flash_sel = 0; test_mode = 0; trim = 0;
    tick(5);
    rst_n = 1;
    tick(2);
    chk("R1 hr", hr, 1); chk("R1 min", min, 0); chk("R1 sec", sec, 0);
    chk("R1 pm", pm, 0); chk("R1 seg", seg_all_on, 0); chk("R10 colon static", colon, 1);

    test_mode = 1;
    eh = 1; epm = 0;
    for (int i = 0; i < 24; i++) begin
      press(1, 10, 10);
      if (eh == 11) begin eh = 12; epm ^= 1; end
      else if (eh == 12) eh = 1;
      else eh++;
      chk("R6 12h hr", hr, eh); chk("R6 pm", pm, epm);
    end

    for (int i = 1; i <= 60; i++) begin
      press(0, 10, 10);
      chk("R5 min step", min, i % 60);
    end
    chk("R5 no carry to hr", hr, 1);

    press(1, 158, 10);
    chk("R9 R4 test repeat", hr, 4);

    press(1, 2, 10);
    chk("R2 short glitch", hr, 4);

    set_en = 0;
    press(1, 20, 10);
    chk("R3 hr ignored", hr, 4);
    s_hr_n = 0; s_min_n = 0; tick(20);
    chk("R3 seg ignored", seg_all_on, 0);
    s_hr_n = 1; s_min_n = 1; tick(10);
    chk("R3 no reset", hr, 4);
    set_en = 1;

    s_hr_n = 0; s_min_n = 0; tick(20);
    chk("R8 all on", seg_all_on, 1);
    s_hr_n = 1; s_min_n = 1; tick(10);
    chk("R8 seg off", seg_all_on, 0);
    chk("R8 reset hr", hr, 1); chk("R8 reset min", min, 0); chk("R8 reset pm", pm, 0);

    mode12 = 0;
    press_both(20, 10);
    chk("R1 24h start", hr, 0);
    eh = 0;
    for (int i = 0; i < 24; i++) begin
      press(1, 10, 10);
      eh = (eh + 1) % 24;
      chk("R6 24h hr", hr, eh);
    end
    chk("R6 24h pm", pm, 0);
    mode12 = 1;
    press_both(20, 10);
    chk("R1 12h restart", hr, 1);

    test_mode = 0;
    tick(300);
    press(1, 158, 400);
    chk("R2 R9 normal debounce rejects", hr, 1);
    press(1, 10240, 400);
    chk("R4 hold 2.5 s", hr, 4);

    flash_sel = 1;
    wait_sec_change(c);
    s_before = sec;
    wait_sec_change(c);
    chk("R11 second length", c, 4096);
    chk("R7 sec inc", sec, (s_before + 1) % 60);
    tick(1);
    chk("R10 colon first half", colon, 1);
    tick(2999);
    chk("R10 colon second half", colon, 0);
    trim = 6'd5;
    wait_sec_change(c);
    wait_sec_change(c);
    wait_sec_change(c);
    chk("R11 trimmed second", c, 4101);
    flash_sel = 0;
    tick(3000);
    chk("R10 colon static", colon, 1);

    test_mode = 1;
    tick(2);
    chk("R5 sec nonzero before", (sec != 0) ? 1 : 0, 1);
    m_before = min;
    press(0, 20, 10);
    chk("R5 min step", min, (m_before + 1) % 60);
    chk("R5 sec cleared", sec, 0);

    s_before = sec; m_before = min; h_before = hr;
    tick(9000);
    chk("R9 sec frozen", sec, s_before);
    chk("R9 min frozen", min, m_before);
    chk("R9 hr frozen", hr, h_before);

    trim = 0;
    rst_n = 0; tick(2); rst_n = 1; tick(2);
    for (int i = 0; i < 59; i++) press(0, 10, 10);
    chk("R5 dut2 min 59", min2, 59);
    test_mode = 0;
    begin
      logic [5:0] s0;
      int n;
      s0 = sec2; n = 0;
      while (sec2 == s0 && n < 1000) begin tick(1); n++; end
    end
    tick(59 * 256 + 128);
    chk("R7 carry sec", sec2, 0);
    chk("R7 carry min", min2, 0);
    chk("R7 carry hr", hr2, 2);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule